// File: doc/BRIEF.md
# Output DC Offset Persistence Detector

This block decides, for each amplifier output channel, whether an excessive DC offset was present for the whole of a test window. A digital comparator bit per channel arrives already synchronized to the block clock. It is high while that channel's output DC level is beyond the trip level of about ±2 V. The block does not report this bit as it stands. It reports whether the bit stayed high without a break between two host reads.

A window opens in the first cycle that the detection enable is high. It also reopens in the cycle after every host read while the enable stays high. The window closes on the next read strobe. That read cycle is the last sample of the window. The verdict is registered in the cycle after the strobe. The value of a read is therefore the verdict of the window that the read itself closed. If short-circuit protection is active in any cycle of a window, every channel's verdict for that window is forced clear.

The verdicts are packed into per-channel diagnostic bytes, together with a status bit that shows whether detection is running. Dropping the enable stops the window and clears the status bit. Cycles spent with the enable low never count against a later window.

Top module: `offs_persist_mon`

## Requirements
- R1: While reset is asserted and right after it, every channel flag, the active status bit and all diagnostic bytes are 0.
- R2: The active status output equals the detection enable input as it was sampled at the previous clock edge. When the enable drops, the active bit therefore clears one cycle later.
- R3: A channel's flag becomes 1 in the cycle after a read strobe when both of these hold: its comparator was high in every cycle from the window start through the read cycle inclusive, and no protection activity occurred in that window.
- R4: If a channel's comparator is low in any cycle of a window, including the read cycle, that channel's flag is 0 after the read that closes the window.
- R5: If the protection-active input is high in any cycle of a window, including the read cycle, all flags are 0 after the read that closes it.
- R6: Each read starts a fresh window. A comparator drop or protection event before a read has no effect on the verdict of the following window.
- R7: Channels are judged independently. A drop on one channel does not change another channel's verdict.
- R8: A read strobe while the enable is low sets all flags to 0. Comparator and protection values during enable-low cycles are ignored by the next window.
- R9: Flags change only in the cycle after a read strobe. Between reads they hold their value.
- R10: Diagnostic byte k occupies bits [8k+7:8k] of the byte bus. Bit 2 of byte k carries the flag of channel k. Bit 7 of the last byte carries the active status. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_en | input | 1 | Offset detection enable (level) |
| cmp_hi | input | NUM_CH | Per-channel synchronized over-threshold comparator bits |
| prot_act | input | 1 | Short-circuit protection active |
| rd_stb | input | 1 | One-cycle pulse per host read of the diagnostic bytes |
| offs_flag | output | NUM_CH | Latched per-channel persistent-offset verdict |
| det_active | output | 1 | Detection running status |
| diag_bytes | output | 8*NUM_CH | Packed diagnostic bytes |

## Verification
The properties assume that the comparator, protection and enable inputs are already synchronous to the clock and free of X after reset. They also assume that a host read appears as a strobe of a single cycle, so every strobe cycle closes exactly one window. The bench drives all inputs on the falling edge and holds them for one full cycle. Each read strobe it applies is a single table row, so reads next to each other are distinct one-cycle pulses, and no input ever changes near the sampling edge.

// File: rtl/offs_pkg.sv
package offs_pkg;
  localparam int BYTE_W   = 8;
  localparam int FLAG_BIT = 2;
  localparam int ACT_BIT  = 7;
endpackage

// File: rtl/offs_void_track.sv
module offs_void_track (
  input  logic clk,
  input  logic rst_n,
  input  logic win_run,
  input  logic win_close,
  input  logic prot_act,
  output logic void_now
);
  logic void_q;

  // Sticky marker of protection activity within the current window.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      void_q <= 1'b0;
    else if (!win_run || win_close)
      void_q <= 1'b0;
    else
      void_q <= void_q | prot_act;
  end

  assign void_now = void_q | prot_act;
endmodule

// File: rtl/offs_chan_persist.sv
module offs_chan_persist (
  input  logic clk,
  input  logic rst_n,
  input  logic win_run,
  input  logic win_close,
  input  logic void_now,
  input  logic cmp,
  output logic flag
);
  logic held_q;
  logic held_now;

  // held_q stays 1 while the comparator has not dropped in the open window.
  assign held_now = held_q & cmp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      held_q <= 1'b1;
    else if (!win_run || win_close)
      held_q <= 1'b1;
    else
      held_q <= held_now;
  end

  // The verdict is captured only when a read closes the window.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag <= 1'b0;
    else if (win_close)
      flag <= win_run & held_now & ~void_now;
  end
endmodule

// File: rtl/offs_byte_pack.sv
module offs_byte_pack #(
  parameter int NUM_CH = 2
) (
  input  logic [NUM_CH-1:0]                   flags,
  input  logic                                active,
  output logic [NUM_CH*offs_pkg::BYTE_W-1:0]  bytes_o
);
  import offs_pkg::*;
  localparam int LAST = NUM_CH - 1;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_byte
    logic [BYTE_W-1:0] b;
    always_comb begin
      b           = '0;
      b[FLAG_BIT] = flags[k];
      if (k == LAST)
        b[ACT_BIT] = active;
    end
    assign bytes_o[k*BYTE_W +: BYTE_W] = b;
  end
endmodule

// File: rtl/offs_persist_mon.sv
module offs_persist_mon #(
  parameter int NUM_CH = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       det_en,
  input  logic [NUM_CH-1:0]          cmp_hi,
  input  logic                       prot_act,
  input  logic                       rd_stb,
  output logic [NUM_CH-1:0]          offs_flag,
  output logic                       det_active,
  output logic [NUM_CH*8-1:0]        diag_bytes
);
  logic void_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      det_active <= 1'b0;
    else
      det_active <= det_en;
  end

  offs_void_track u_void (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_run   (det_en),
    .win_close (rd_stb),
    .prot_act  (prot_act),
    .void_now  (void_now)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    offs_chan_persist u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .win_run   (det_en),
      .win_close (rd_stb),
      .void_now  (void_now),
      .cmp       (cmp_hi[c]),
      .flag      (offs_flag[c])
    );
  end

  offs_byte_pack #(.NUM_CH(NUM_CH)) u_pack (
    .flags   (offs_flag),
    .active  (det_active),
    .bytes_o (diag_bytes)
  );
endmodule

// File: rtl/offs_persist_chk.sv
module offs_persist_chk #(
  parameter int NUM_CH = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                det_en,
  input logic [NUM_CH-1:0]   cmp_hi,
  input logic                prot_act,
  input logic                rd_stb,
  input logic [NUM_CH-1:0]   offs_flag,
  input logic                det_active,
  input logic [NUM_CH*8-1:0] diag_bytes
);
  assert_active_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> det_active == $past(det_en));

  assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(offs_flag));

  assert_drop_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> (offs_flag & ~$past(cmp_hi)) == '0);

  assert_prot_voids_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && prot_act) |=> offs_flag == '0);

  assert_idle_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !det_en) |=> offs_flag == '0);

  assert_byte_map_R10: assert property (@(posedge clk) disable iff (!rst_n)
    diag_bytes[2] == offs_flag[0] && diag_bytes[NUM_CH*8-1] == det_active);
endmodule

bind offs_persist_mon offs_persist_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .det_en     (det_en),
  .cmp_hi     (cmp_hi),
  .prot_act   (prot_act),
  .rd_stb     (rd_stb),
  .offs_flag  (offs_flag),
  .det_active (det_active),
  .diag_bytes (diag_bytes)
);

// File: tb/offs_persist_mon_test.sv
module offs_persist_mon_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;
  localparam int NVEC = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic det_en = 1'b0;
  logic [NCH-1:0] cmp_hi = '0;
  logic prot_act = 1'b0;
  logic rd_stb = 1'b0;
  logic [NCH-1:0] offs_flag;
  logic det_active;
  logic [NCH*8-1:0] diag_bytes;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  offs_persist_mon #(.NUM_CH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .det_en(det_en), .cmp_hi(cmp_hi),
    .prot_act(prot_act), .rd_stb(rd_stb), .offs_flag(offs_flag),
    .det_active(det_active), .diag_bytes(diag_bytes)
  );

  // Row: {en, prot, rd, cmp[1:0], exp_flag[1:0], exp_active}
  localparam logic [7:0] VEC [NVEC] = '{
    8'b0_0_0_00_00_0,  // idle
    8'b1_0_0_11_00_1,  // window opens (R2)
    8'b1_0_0_11_00_1,
    8'b1_0_1_11_11_1,  // R3 persistent on both
    8'b1_0_0_10_11_1,  // ch0 drops, flags hold (R9)
    8'b1_0_0_11_11_1,
    8'b1_0_1_11_10_1,  // R4/R7 only ch1 persisted
    8'b1_1_0_11_10_1,  // protection in window
    8'b1_0_1_11_00_1,  // R5 voided
    8'b1_0_1_11_11_1,  // R6 fresh one-cycle window
    8'b0_0_0_00_11_0,  // R2 active clears, flags hold
    8'b0_1_0_00_11_0,
    8'b1_0_0_11_11_1,  // R8 disabled cycles ignored
    8'b1_0_1_11_11_1,
    8'b0_0_1_11_00_0,  // R8 read while disabled
    8'b1_0_1_01_01_1,  // R7 single-cycle window
    8'b1_1_1_11_00_1   // R5 protection in read cycle
  };

  function automatic logic [NCH*8-1:0] exp_bytes(logic [NCH-1:0] f, logic a);
    logic [NCH*8-1:0] r = '0;
    for (int k = 0; k < NCH; k++) r[k*8+2] = f[k];
    r[NCH*8-1] = a;
    return r;
  endfunction

  task automatic check(string req, logic [NCH-1:0] ef, logic ea);
    logic [NCH*8-1:0] eb = exp_bytes(ef, ea);
    total++;
    if (offs_flag !== ef || det_active !== ea || diag_bytes !== eb) begin
      bad++;
      $display("FAIL %s: flag=%b active=%b bytes=%h expected flag=%b active=%b bytes=%h (R10 map)",
               req, offs_flag, det_active, diag_bytes, ef, ea, eb);
    end
  endtask

  initial begin
    @(negedge clk);
    check("R1 in reset", 2'b00, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 2'b00, 1'b0);
    for (int i = 0; i < NVEC; i++) begin
      {det_en, prot_act, rd_stb, cmp_hi} = VEC[i][7:3];
      @(negedge clk);
      check($sformatf("R3-table row %0d", i), VEC[i][2:1], VEC[i][0]);
    end
    // Directed: build flags, then reset mid-run clears them (R1).
    det_en = 1'b1; prot_act = 1'b0; cmp_hi = 2'b11; rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    check("R3 directed read", 2'b11, 1'b1);
    rst_n = 1'b0;
    #1;
    check("R1 mid-run reset", 2'b00, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    // Long window with a dip in the middle on ch1 only (R4, R7).
    for (int j = 0; j < 20; j++) begin
      cmp_hi = (j == 10) ? 2'b01 : 2'b11;
      @(negedge clk);
    end
    cmp_hi = 2'b11; rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    check("R4 long window dip", 2'b01, 1'b1);
    // Next window is fresh despite earlier dip (R6).
    repeat (5) @(negedge clk);
    check("R9 hold between reads", 2'b01, 1'b1);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    check("R6 fresh window", 2'b11, 1'b1);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule